// File: doc/BRIEF.md
# Indexed Effective Address Calculator

This block turns one addressing request into a 16-bit effective address. A request carries an addressing mode, the postbyte, the two bytes that follow it in the instruction stream, the current index registers (X, Y, SP), the program counter and the two 8-bit accumulators. The block decodes the postbyte, picks a base register, forms the offset and adds the two. It reports how many extra offset bytes the instruction consumed and whether the computed address holds a pointer that the sequencer must read next. For auto-update forms it also returns the updated index value, with its register code and a write enable.

Requests enter on a valid/ready channel and results leave on another, with one register stage between them. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. Its result is offered on `out_valid` from the next cycle. While `out_ready` is low the result stays on the outputs unchanged and `in_ready` is low. `in_ready` is high whenever the stage is empty or is being emptied in the same cycle. The sequencer performs the indirect pointer read itself.

Top module: `idx_ea_calc`

## Requirements
- R1: A request taken on an edge is offered on the outputs from the following cycle, and results leave in the order the requests were taken. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, every output field holds its value.
- R2: Mode code 01 (direct) gives `out_ea = {8'h00, op_hi}` with extra count 1. Mode code 10 (extended) gives `out_ea = {op_hi, op_lo}` with extra count 2.
- R3: Mode code 00 (no address: inherent, immediate, relative) gives address 0, extra count 0, and no indirect or write-back.
- R4: With mode code 11 and postbyte bit 5 clear, the base is register code pb[7:6] (00 X, 01 Y, 10 SP, 11 PC). The address is base plus pb[4:0] sign-extended from bit 4, with extra count 0.
- R5: Postbyte 111rr00s (rr = pb[4:3]) gives base plus `{{8{s}}, op_hi}`, with extra count 1.
- R6: Postbyte 111rr010 gives base plus `{op_hi, op_lo}`, with extra count 2.
- R7: Postbyte 111rr1aa with aa = 00, 01 or 10 adds A zero-extended, B zero-extended, or D = `{A, B}`, with extra count 0.
- R8: Postbyte 111rr011 gives base plus `{op_hi, op_lo}` with extra count 2. Postbyte 111rr111 gives base plus D with extra count 0. Both raise `out_indirect`. Every other request leaves it low.
- R9: Postbyte rr1pnnnn with rr not 11 is an auto-update. The step is nnnn+1 when nnnn[3] is 0, and nnnn sign-extended when it is 1. The new value is base plus step. `out_wb_en` is 1, `out_wb_sel` is rr and `out_wb_val` is the new value. p = 0 (pre) gives the new value as the address. p = 1 (post) gives the original base. The extra count is 0. PC is never auto-updated.
- R10: Every request that is not an auto-update leaves `out_wb_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_mode | input | 2 | 00 none, 01 direct, 10 extended, 11 indexed |
| in_pb | input | 8 | Postbyte |
| in_op_hi | input | 8 | First byte after the postbyte or opcode |
| in_op_lo | input | 8 | Second byte after it |
| in_x | input | 16 | Index register X |
| in_y | input | 16 | Index register Y |
| in_sp | input | 16 | Stack pointer |
| in_pc | input | 16 | Program counter used as base |
| in_acc_a | input | 8 | Accumulator A |
| in_acc_b | input | 8 | Accumulator B |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_ea | output | 16 | Effective address |
| out_extra | output | 2 | Offset bytes consumed after the postbyte |
| out_indirect | output | 1 | Address holds a 16-bit pointer to read |
| out_wb_en | output | 1 | Index register update present |
| out_wb_sel | output | 2 | Register code to update |
| out_wb_val | output | 16 | Updated register value |

## Verification
The stage can drain a held result and take a new request on the same edge. The bench provokes this by keeping a request waiting while `out_ready` is driven from a pseudo-random sequence, so that acceptance and hand-off coincide often. The scoreboard judges it: every result popped must match, field for field, the oldest request still expected, and none may be lost or repeated. Address forms that share the one adder, such as a post-update beside a pre-update on the same register, are mixed in the same stream so that a wrong select would show in the address or the write-back value.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;
  localparam int AW = 16;
  localparam int BW = 8;

  typedef enum logic [1:0] {
    MD_NONE = 2'b00,
    MD_DIR  = 2'b01,
    MD_EXT  = 2'b10,
    MD_IDX  = 2'b11
  } amode_t;

  typedef struct packed {
    logic [AW-1:0] ea;
    logic [1:0]    extra;
    logic          indirect;
    logic          wb_en;
    logic [1:0]    wb_sel;
    logic [AW-1:0] wb_val;
  } ea_res_t;
endpackage

// File: rtl/idx_ea_decode.sv
module idx_ea_decode
  import idx_ea_pkg::*;
(
  input  logic [1:0]    mode,
  input  logic [BW-1:0] pb,
  input  logic [BW-1:0] op_hi,
  input  logic [BW-1:0] op_lo,
  input  logic [BW-1:0] acc_a,
  input  logic [BW-1:0] acc_b,
  output logic          use_base,
  output logic [1:0]    base_sel,
  output logic [AW-1:0] offset,
  output logic [AW-1:0] const_addr,
  output logic [1:0]    extra,
  output logic          indirect,
  output logic          auto_en,
  output logic          post
);
  localparam int PADW = AW - BW;

  logic [AW-1:0] step;

  always_comb begin
    if (pb[3]) step = {{(AW-4){1'b1}}, pb[3:0]};
    else       step = {{(AW-4){1'b0}}, pb[3:0]} + {{(AW-1){1'b0}}, 1'b1};
  end

  always_comb begin
    use_base   = 1'b0;
    base_sel   = 2'b00;
    offset     = '0;
    const_addr = '0;
    extra      = 2'd0;
    indirect   = 1'b0;
    auto_en    = 1'b0;
    post       = 1'b0;
    unique case (amode_t'(mode))
      MD_DIR: begin
        const_addr = {{PADW{1'b0}}, op_hi};
        extra      = 2'd1;
      end
      MD_EXT: begin
        const_addr = {op_hi, op_lo};
        extra      = 2'd2;
      end
      MD_IDX: begin
        use_base = 1'b1;
        if (!pb[5]) begin
          base_sel = pb[7:6];
          offset   = {{(AW-5){pb[4]}}, pb[4:0]};
        end else if (pb[7:6] != 2'b11) begin
          base_sel = pb[7:6];
          auto_en  = 1'b1;
          post     = pb[4];
          offset   = step;
        end else begin
          base_sel = pb[4:3];
          if (!pb[2]) begin
            if (!pb[1]) begin
              offset = {{PADW{pb[0]}}, op_hi};
              extra  = 2'd1;
            end else begin
              offset   = {op_hi, op_lo};
              extra    = 2'd2;
              indirect = pb[0];
            end
          end else begin
            unique case (pb[1:0])
              2'b00:   offset = {{PADW{1'b0}}, acc_a};
              2'b01:   offset = {{PADW{1'b0}}, acc_b};
              default: offset = {acc_a, acc_b};
            endcase
            indirect = (pb[1:0] == 2'b11);
          end
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/idx_ea_agen.sv
module idx_ea_agen
  import idx_ea_pkg::*;
(
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] offset,
  input  logic [AW-1:0] const_addr,
  input  logic          use_base,
  input  logic          auto_en,
  input  logic          post,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] wb_val
);
  logic [AW-1:0] sum;

  assign sum    = base + offset;
  assign wb_val = sum;

  always_comb begin
    if (!use_base)           ea = const_addr;
    else if (auto_en && post) ea = base;
    else                      ea = sum;
  end
endmodule

// File: rtl/idx_ea_stage.sv
module idx_ea_stage
  import idx_ea_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  output logic    in_ready,
  input  ea_res_t in_data,
  output logic    out_valid,
  input  logic    out_ready,
  output ea_res_t out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_drain_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  assert_take_shows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
endmodule

// File: rtl/idx_ea_calc.sv
module idx_ea_calc
  import idx_ea_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_mode,
  input  logic [BW-1:0] in_pb,
  input  logic [BW-1:0] in_op_hi,
  input  logic [BW-1:0] in_op_lo,
  input  logic [AW-1:0] in_x,
  input  logic [AW-1:0] in_y,
  input  logic [AW-1:0] in_sp,
  input  logic [AW-1:0] in_pc,
  input  logic [BW-1:0] in_acc_a,
  input  logic [BW-1:0] in_acc_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_ea,
  output logic [1:0]    out_extra,
  output logic          out_indirect,
  output logic          out_wb_en,
  output logic [1:0]    out_wb_sel,
  output logic [AW-1:0] out_wb_val
);
  localparam int NREG = 4;

  logic [AW-1:0] regs [NREG];
  logic          use_base, auto_en, post, indirect;
  logic [1:0]    base_sel, extra;
  logic [AW-1:0] offset, const_addr, ea, wb_val;
  ea_res_t       res, held;

  assign regs[0] = in_x;
  assign regs[1] = in_y;
  assign regs[2] = in_sp;
  assign regs[3] = in_pc;

  idx_ea_decode u_dec (
    .mode(in_mode), .pb(in_pb), .op_hi(in_op_hi), .op_lo(in_op_lo),
    .acc_a(in_acc_a), .acc_b(in_acc_b),
    .use_base(use_base), .base_sel(base_sel), .offset(offset),
    .const_addr(const_addr), .extra(extra), .indirect(indirect),
    .auto_en(auto_en), .post(post)
  );

  idx_ea_agen u_agen (
    .base(regs[base_sel]), .offset(offset), .const_addr(const_addr),
    .use_base(use_base), .auto_en(auto_en), .post(post),
    .ea(ea), .wb_val(wb_val)
  );

  always_comb begin
    res.ea       = ea;
    res.extra    = extra;
    res.indirect = indirect;
    res.wb_en    = auto_en;
    res.wb_sel   = auto_en ? base_sel : 2'b00;
    res.wb_val   = auto_en ? wb_val : '0;
  end

  idx_ea_stage u_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(res), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(held)
  );

  assign out_ea       = held.ea;
  assign out_extra    = held.extra;
  assign out_indirect = held.indirect;
  assign out_wb_en    = held.wb_en;
  assign out_wb_sel   = held.wb_sel;
  assign out_wb_val   = held.wb_val;

  assert_auto_not_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_wb_en |-> out_wb_sel != 2'b11 && out_extra == 2'd0);

  assert_ptr_extra_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_indirect |-> out_extra != 2'd1 && !out_wb_en);

  assert_none_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_mode == 2'b00 |=> out_ea == '0 && out_extra == 2'd0);

  assert_direct_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_mode == 2'b01 |=> out_ea[15:8] == 8'h00 && out_extra == 2'd1);
endmodule

// File: tb/sim_idx_ea_calc.sv
module sim_idx_ea_calc;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  typedef struct packed {
    logic [15:0] ea;
    logic [1:0]  ex;
    logic        ind;
    logic        wb;
    logic [1:0]  sel;
    logic [15:0] val;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_mode = '0;
  logic [7:0]  in_pb = '0, in_op_hi = '0, in_op_lo = '0, in_acc_a = '0, in_acc_b = '0;
  logic [15:0] in_x = '0, in_y = '0, in_sp = '0, in_pc = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_ea, out_wb_val;
  logic [1:0]  out_extra, out_wb_sel;
  logic        out_indirect, out_wb_en;

  int    errors = 0;
  int    checks = 0;
  int    cyc = 0;
  int    pushed = 0;
  int    popped = 0;
  bit    bp_on = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  exp_t  expq[$];
  string tagq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_ea_calc u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_pb(in_pb), .in_op_hi(in_op_hi), .in_op_lo(in_op_lo),
    .in_x(in_x), .in_y(in_y), .in_sp(in_sp), .in_pc(in_pc),
    .in_acc_a(in_acc_a), .in_acc_b(in_acc_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_ea(out_ea),
    .out_extra(out_extra), .out_indirect(out_indirect), .out_wb_en(out_wb_en),
    .out_wb_sel(out_wb_sel), .out_wb_val(out_wb_val)
  );

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= bp_on ? lfsr[3] : 1'b1;
  end

  function automatic logic [15:0] pick(input logic [1:0] rr);
    case (rr)
      2'd0: pick = in_x;
      2'd1: pick = in_y;
      2'd2: pick = in_sp;
      default: pick = in_pc;
    endcase
  endfunction

  function automatic void model(output exp_t e, output string tag);
    logic [15:0] b, stp, nv;
    e = '0;
    tag = "R3";
    if (in_mode == 2'b01) begin
      e.ea = {8'h00, in_op_hi}; e.ex = 2'd1; tag = "R2";
    end else if (in_mode == 2'b10) begin
      e.ea = {in_op_hi, in_op_lo}; e.ex = 2'd2; tag = "R2";
    end else if (in_mode == 2'b11) begin
      if (in_pb[5] == 1'b0) begin
        b = pick(in_pb[7:6]);
        e.ea = b + {{11{in_pb[4]}}, in_pb[4:0]}; tag = "R4";
      end else if (in_pb[7:6] != 2'b11) begin
        b = pick(in_pb[7:6]);
        stp = in_pb[3] ? {12'hFFF, in_pb[3:0]} : ({12'h000, in_pb[3:0]} + 16'd1);
        nv = b + stp;
        e.ea = in_pb[4] ? b : nv;
        e.wb = 1'b1; e.sel = in_pb[7:6]; e.val = nv; tag = "R9";
      end else begin
        b = pick(in_pb[4:3]);
        case (in_pb[2:0])
          3'b000, 3'b001: begin e.ea = b + {{8{in_pb[0]}}, in_op_hi}; e.ex = 2'd1; tag = "R5"; end
          3'b010: begin e.ea = b + {in_op_hi, in_op_lo}; e.ex = 2'd2; tag = "R6"; end
          3'b011: begin e.ea = b + {in_op_hi, in_op_lo}; e.ex = 2'd2; e.ind = 1'b1; tag = "R8"; end
          3'b100: begin e.ea = b + {8'h00, in_acc_a}; tag = "R7"; end
          3'b101: begin e.ea = b + {8'h00, in_acc_b}; tag = "R7"; end
          3'b110: begin e.ea = b + {in_acc_a, in_acc_b}; tag = "R7"; end
          default: begin e.ea = b + {in_acc_a, in_acc_b}; e.ind = 1'b1; tag = "R8"; end
        endcase
      end
    end
  endfunction

  task automatic send(input logic [1:0] m, input logic [7:0] pb, input logic [7:0] hi, input logic [7:0] lo);
    exp_t  e;
    string t;
    in_mode = m; in_pb = pb; in_op_hi = hi; in_op_lo = lo;
    in_valid = 1'b1;
    model(e, t);
    forever begin
      if (in_ready) begin
        expq.push_back(e); tagq.push_back(t); pushed++;
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  // scoreboard monitor; hold check for R1 under stall
  exp_t  last;
  bit    stalled = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stalled) begin
        checks++;
        if (!out_valid || {out_ea, out_extra, out_indirect, out_wb_en, out_wb_sel, out_wb_val} != last) begin
          errors++;
          $display("FAIL R1 held result changed: got %h expected %h",
                   {out_ea, out_extra, out_indirect, out_wb_en, out_wb_sel, out_wb_val}, last);
        end
      end
      stalled = out_valid && !out_ready;
      last = {out_ea, out_extra, out_indirect, out_wb_en, out_wb_sel, out_wb_val};
      if (out_valid && out_ready) begin
        exp_t  e;
        string t;
        checks++;
        if (expq.size() == 0) begin
          errors++;
          $display("FAIL R1 unexpected result: got ea=%h expected none", out_ea);
        end else begin
          e = expq.pop_front(); t = tagq.pop_front(); popped++;
          if (out_ea != e.ea || out_extra != e.ex || out_indirect != e.ind) begin
            errors++;
            $display("FAIL %s ea/extra/ind got %h/%0d/%0d expected %h/%0d/%0d",
                     t, out_ea, out_extra, out_indirect, e.ea, e.ex, e.ind);
          end
          checks++;
          if (out_wb_en != e.wb || (e.wb && (out_wb_sel != e.sel || out_wb_val != e.val))) begin
            errors++;
            $display("FAIL %s wb en/sel/val got %0d/%0d/%h expected %0d/%0d/%h",
                     e.wb ? "R9" : "R10", out_wb_en, out_wb_sel, out_wb_val, e.wb, e.sel, e.val);
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WATCHDOG) begin
      errors++; checks++;
      $display("FAIL watchdog expired: got cycle %0d expected below %0d", cyc, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset state: got valid=%b ready=%b expected 0/1", out_valid, in_ready);
    end
    in_x = 16'h1000; in_y = 16'h2000; in_sp = 16'h3FF0; in_pc = 16'h8000;
    in_acc_a = 8'h12; in_acc_b = 8'hF0;
    send(2'b00, 8'h00, 8'h55, 8'h66);          // R3
    send(2'b01, 8'h00, 8'h9A, 8'h00);          // R2 direct
    send(2'b10, 8'h00, 8'hC3, 8'h21);          // R2 extended
    send(2'b11, 8'h0F, 8'h00, 8'h00);          // R4 X +15
    send(2'b11, 8'h50, 8'h00, 8'h00);          // R4 Y -16
    send(2'b11, 8'hDF, 8'h00, 8'h00);          // R4 PC -1
    send(2'b11, 8'hE8, 8'h80, 8'h00);          // R5 Y +128
    send(2'b11, 8'hF1, 8'h02, 8'h00);          // R5 SP, negative
    send(2'b11, 8'hE2, 8'h7F, 8'hFF);          // R6 X
    send(2'b11, 8'hE3, 8'h00, 8'h10);          // R8 16-bit indirect X
    send(2'b11, 8'hEC, 8'h00, 8'h00);          // R7 A
    send(2'b11, 8'hED, 8'h00, 8'h00);          // R7 B
    send(2'b11, 8'hFE, 8'h00, 8'h00);          // R7 D on PC
    send(2'b11, 8'hE7, 8'h00, 8'h00);          // R8 D indirect
    send(2'b11, 8'h22, 8'h00, 8'h00);          // R9 pre +3 X
    send(2'b11, 8'h72, 8'h00, 8'h00);          // R9 post +3 Y
    send(2'b11, 8'hAF, 8'h00, 8'h00);          // R9 pre -1 SP
    send(2'b11, 8'hB8, 8'h00, 8'h00);          // R9 post -8 SP
    send(2'b11, 8'h27, 8'h00, 8'h00);          // R9 pre +8 X
    bp_on = 1'b1;                              // R1 back-pressure phase
    for (int i = 0; i < 300; i++) begin
      in_x = $urandom; in_y = $urandom; in_sp = $urandom; in_pc = $urandom;
      in_acc_a = $urandom; in_acc_b = $urandom;
      send(2'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
    end
    bp_on = 1'b0;
    for (int i = 0; i < 100 && expq.size() != 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    checks++;
    if (popped != pushed) begin
      errors++;
      $display("FAIL R1 result count: got %0d expected %0d", popped, pushed);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule